// File: doc/BRIEF.md
# Memory-Mapped 32-Pin GPIO Controller

This block is a general-purpose I/O controller for 32 pins. It sits on a simple register bus that is one 32-bit word wide, with a word address, a write enable, write data and combinational read data. For every pin, software sets an output level, a drive enable, an open-drain mode, and two 2-bit source selectors. One selector picks where the pin's data comes from and the other picks where its enable comes from. Each selector chooses either the plain GPIO registers or one of three alternate-function inputs.

Register bits follow big-endian numbering: pin 0 sits in bit 31 of every one-bit-per-pin word. Each two-bit selector field sits in a low word (pins 0..15) or a high word (pins 16..31). On the pin side, vectors are indexed by pin number, so `pin_out[n]` is pin n. The pin levels are synchronized by two flops and can be read back through a read-only input word. Two groups of words are kept as plain read/write storage with no effect on the pins: three receive words and six input-select words.

Top module: `gpio32_ctrl`

## Requirements
- R1: After reset every register reads zero, and `pin_oe` and `pin_out` are all zero, so every pin floats.
- R2: The word addresses are: 0 output data, 1 drive enable, 2 data-select low, 3 data-select high, 4 enable-select low, 5 enable-select high, 6 open-drain, 8..10 receive storage, and 12..17 input-select storage. A write to any of these words is read back unchanged, and a cycle without a write leaves all stored words unchanged.
- R3: Pin n maps to register bit 31-n. With both of its selectors at 0, drive enable set and open-drain clear, pin n drives `pin_out[n]` equal to output-data bit 31-n and asserts `pin_oe[n]`.
- R4: With its enable selector at 0, a pin whose drive-enable bit (31-n) is clear has `pin_oe[n]` low.
- R5: The selector field for pin n < 16 is bits [31-2n : 30-2n] of the low word. The field for pin n >= 16 is bits [31-2(n-16) : 30-2(n-16)] of the high word.
- R6: A data selector value s in 1..3 drives the pin's data from `alt_dat[s-1][n]`. An enable selector value s in 1..3 takes the pin's enable from `alt_en[s-1][n]`. The two selectors act independently of each other.
- R7: With open-drain bit 31-n set and the pin enabled, data 0 gives `pin_out[n]`=0 with `pin_oe[n]`=1, and data 1 gives `pin_oe[n]`=0. An open-drain pin never drives high.
- R8: Word 7 returns `pin_in[n]` at bit 31-n. A level applied before a clock edge is visible after the second rising edge and not after the first.
- R9: Writes to word 7 (input) and word 11 (reserved) are ignored. Word 11 and the unused words 18..31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| alt_dat | input | 3x32 | Alternate-function data sources, [source][pin] |
| alt_en | input | 3x32 | Alternate-function enable sources, [source][pin] |
| pin_in | input | 32 | Pin levels, indexed by pin |
| pin_out | output | 32 | Pin output values, indexed by pin |
| pin_oe | output | 32 | Pin output enables, indexed by pin |

## Verification
Several rules are checked by the embedded properties on every cycle:
- an open-drain pin never drives high;
- a floated pin using the plain enable source never asserts its enable;
- a write to the output word lands on the next edge, and idle cycles keep storage stable;
- the reserved word reads zero.

Other rules can only be shown by the bench's scenarios, because they depend on specific stimulus and timing:
- the exact address map;
- the reversed bit numbering;
- where the selector fields sit in the low and high words;
- routing from each alternate source;
- the two-edge synchronizer latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPIN   = 32;
    localparam int NALT   = 3;
    localparam int HALF   = NPIN / 2;
    localparam int NRX    = 3;
    localparam int NISEL  = 6;

    typedef enum logic [4:0] {
        A_DOUT = 5'd0,  A_DRV  = 5'd1,  A_OSL  = 5'd2,  A_OSH  = 5'd3,
        A_ESL  = 5'd4,  A_ESH  = 5'd5,  A_OD   = 5'd6,  A_IN   = 5'd7,
        A_RX0  = 5'd8,  A_RX1  = 5'd9,  A_RX2  = 5'd10, A_RSV  = 5'd11,
        A_IS0  = 5'd12, A_IS1  = 5'd13, A_IS2  = 5'd14, A_IS3  = 5'd15,
        A_IS4  = 5'd16, A_IS5  = 5'd17
    } gpio_addr_e;

    typedef struct packed {
        logic [NPIN-1:0]             dout;
        logic [NPIN-1:0]             drv;
        logic [NPIN-1:0]             osel_lo;
        logic [NPIN-1:0]             osel_hi;
        logic [NPIN-1:0]             esel_lo;
        logic [NPIN-1:0]             esel_hi;
        logic [NPIN-1:0]             odrain;
        logic [NRX-1:0][NPIN-1:0]    rx;
        logic [NISEL-1:0][NPIN-1:0]  isel;
    } gpio_regs_t;

    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
    } sync_regs_t;
endpackage

// File: rtl/gpio_insync.sv
module gpio_insync
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] level
);
    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level = sync_q.s2;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            we,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] in_word,
    output logic [NPIN-1:0] rdata,
    output gpio_regs_t      regs
);
    gpio_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                A_DOUT: regs_d.dout    = wdata;
                A_DRV:  regs_d.drv     = wdata;
                A_OSL:  regs_d.osel_lo = wdata;
                A_OSH:  regs_d.osel_hi = wdata;
                A_ESL:  regs_d.esel_lo = wdata;
                A_ESH:  regs_d.esel_hi = wdata;
                A_OD:   regs_d.odrain  = wdata;
                A_RX0:  regs_d.rx[0]   = wdata;
                A_RX1:  regs_d.rx[1]   = wdata;
                A_RX2:  regs_d.rx[2]   = wdata;
                A_IS0:  regs_d.isel[0] = wdata;
                A_IS1:  regs_d.isel[1] = wdata;
                A_IS2:  regs_d.isel[2] = wdata;
                A_IS3:  regs_d.isel[3] = wdata;
                A_IS4:  regs_d.isel[4] = wdata;
                A_IS5:  regs_d.isel[5] = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            A_DOUT:  rdata = regs_q.dout;
            A_DRV:   rdata = regs_q.drv;
            A_OSL:   rdata = regs_q.osel_lo;
            A_OSH:   rdata = regs_q.osel_hi;
            A_ESL:   rdata = regs_q.esel_lo;
            A_ESH:   rdata = regs_q.esel_hi;
            A_OD:    rdata = regs_q.odrain;
            A_IN:    rdata = in_word;
            A_RX0:   rdata = regs_q.rx[0];
            A_RX1:   rdata = regs_q.rx[1];
            A_RX2:   rdata = regs_q.rx[2];
            A_IS0:   rdata = regs_q.isel[0];
            A_IS1:   rdata = regs_q.isel[1];
            A_IS2:   rdata = regs_q.isel[2];
            A_IS3:   rdata = regs_q.isel[3];
            A_IS4:   rdata = regs_q.isel[4];
            A_IS5:   rdata = regs_q.isel[5];
            default: rdata = '0;
        endcase
    end

    assign regs = regs_q;

    // R2: a write to the data word is visible on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_DOUT) |=> (regs_q.dout == $past(wdata)));

    // R2: storage holds when no write is issued
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  gpio_regs_t                regs,
    input  logic [NALT-1:0][NPIN-1:0] alt_dat,
    input  logic [NALT-1:0][NPIN-1:0] alt_en,
    output logic [NPIN-1:0]           pin_out,
    output logic [NPIN-1:0]           pin_oe
);
    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        localparam int B  = NPIN - 1 - n;
        localparam int K  = n % HALF;
        localparam int FH = NPIN - 1 - 2 * K;

        logic [1:0] osel, esel;
        logic       dat, en, od;

        if (n < HALF) begin : g_lo
            assign osel = regs.osel_lo[FH -: 2];
            assign esel = regs.esel_lo[FH -: 2];
        end else begin : g_hi
            assign osel = regs.osel_hi[FH -: 2];
            assign esel = regs.esel_hi[FH -: 2];
        end

        always_comb begin
            case (osel)
                2'd1:    dat = alt_dat[0][n];
                2'd2:    dat = alt_dat[1][n];
                2'd3:    dat = alt_dat[2][n];
                default: dat = regs.dout[B];
            endcase
            case (esel)
                2'd1:    en = alt_en[0][n];
                2'd2:    en = alt_en[1][n];
                2'd3:    en = alt_en[2][n];
                default: en = regs.drv[B];
            endcase
        end

        assign od         = regs.odrain[B];
        assign pin_out[n] = od ? 1'b0 : dat;
        assign pin_oe[n]  = od ? (en & ~dat) : en;

        // R4: plain-enable pin with drive bit clear stays floating
        p_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (esel == 2'd0 && !regs.drv[B]) |-> !pin_oe[n]);
    end

    // R7: an open-drain pin is never actively driven high
    p_od_no_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pin_out & {<<{regs.odrain}}) == '0));
endmodule

// File: rtl/gpio32_ctrl.sv
module gpio32_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [NPIN-1:0]           bus_wdata,
    output logic [NPIN-1:0]           bus_rdata,
    input  logic [NALT-1:0][NPIN-1:0] alt_dat,
    input  logic [NALT-1:0][NPIN-1:0] alt_en,
    input  logic [NPIN-1:0]           pin_in,
    output logic [NPIN-1:0]           pin_out,
    output logic [NPIN-1:0]           pin_oe
);
    gpio_regs_t      regs;
    logic [NPIN-1:0] level, in_word;

    gpio_insync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level)
    );

    // pin n appears at register bit NPIN-1-n
    assign in_word = {<<{level}};

    gpio_regfile #(.AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .in_word (in_word),
        .rdata   (bus_rdata),
        .regs    (regs)
    );

    gpio_pinmux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .regs    (regs),
        .alt_dat (alt_dat),
        .alt_en  (alt_en),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R9: the reserved word always reads zero
    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_RSV)) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio32_ctrl_test.sv
module gpio32_ctrl_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [2:0][31:0]  alt_dat = '0;
    logic [2:0][31:0]  alt_en = '0;
    logic [31:0]       pin_in = '0;
    logic [31:0]       pin_out, pin_oe;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    gpio32_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_dat(alt_dat),
        .alt_en(alt_en), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {addr, write data, expected read-back}
    localparam int NV = 15;
    localparam logic [68:0] VEC [NV] = '{
        {5'd0,  32'hA5A5_0F0F, 32'hA5A5_0F0F},
        {5'd1,  32'h1234_5678, 32'h1234_5678},
        {5'd2,  32'hFFFF_0000, 32'hFFFF_0000},
        {5'd3,  32'h0000_FFFF, 32'h0000_FFFF},
        {5'd4,  32'h8000_0001, 32'h8000_0001},
        {5'd5,  32'h0F0F_F0F0, 32'h0F0F_F0F0},
        {5'd6,  32'h5555_AAAA, 32'h5555_AAAA},
        {5'd7,  32'hFFFF_FFFF, 32'h0000_0000},
        {5'd8,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {5'd9,  32'hCAFE_F00D, 32'hCAFE_F00D},
        {5'd10, 32'h0BAD_C0DE, 32'h0BAD_C0DE},
        {5'd11, 32'hFFFF_FFFF, 32'h0000_0000},
        {5'd12, 32'h1357_9BDF, 32'h1357_9BDF},
        {5'd17, 32'h2468_ACE0, 32'h2468_ACE0},
        {5'd20, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        for (int a = 0; a < 18; a++) begin
            rd(5'(a), r);
            chk("R1 reg", r, 32'h0);
        end

        // R2 / R9: table of writes and read-backs
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64], r);
            if (VEC[i][68:64] == 5'd7 || VEC[i][68:64] >= 5'd11 && VEC[i][68:64] != 5'd12
                && VEC[i][68:64] != 5'd17)
                chk("R9 ignored", r, VEC[i][31:0]);
            else
                chk("R2 readback", r, VEC[i][31:0]);
        end
        rd(5'd8, r);
        chk("R2 hold", r, 32'hDEAD_BEEF);

        // R3: bit reversal, plain source
        do_reset();
        wr(5'd0, 32'hC000_0000);
        wr(5'd1, 32'hFFFF_FFFF);
        chk("R3 pin_out", pin_out, 32'h0000_0003);
        chk("R3 pin_oe", pin_oe, 32'hFFFF_FFFF);

        // R4: float by clearing drive bits
        wr(5'd1, 32'h4000_0000);
        chk("R4 pin_oe", pin_oe, 32'h0000_0002);

        // R5 / R6: data selectors in low and high words
        do_reset();
        alt_dat[0] = 32'h0000_0001;
        alt_dat[1] = 32'hFFFF_FFFF;
        alt_dat[2] = 32'h8000_0000;
        wr(5'd1, 32'hFFFF_FFFF);
        wr(5'd2, 32'h4000_0000);
        wr(5'd3, 32'h0000_0003);
        chk("R5 R6 data select", pin_out, 32'h8000_0001);
        wr(5'd2, 32'h0000_0002);
        chk("R5 pin15 source 2", pin_out, 32'h8000_8000);
        // enable selectors: pin16 source 3, pin15 source 2, alt enables zero
        wr(5'd5, 32'hC000_0000);
        wr(5'd4, 32'h0000_0002);
        chk("R6 enable select", pin_oe, 32'hFFFE_7FFF);
        alt_en[2] = 32'h0001_0000;
        #1;
        chk("R6 alt enable", pin_oe, 32'hFFFF_7FFF);

        // R7: open drain on pins 2 (data 1) and 3 (data 0)
        do_reset();
        alt_dat = '0; alt_en = '0;
        wr(5'd0, 32'h2000_0000);
        wr(5'd1, 32'hFFFF_FFFF);
        wr(5'd6, 32'h3000_0000);
        chk("R7 od out", pin_out & 32'hC, 32'h0);
        chk("R7 od oe", pin_oe, 32'hFFFF_FFFB);

        // R8: synchronizer latency, pin 0 at bit 31
        @(negedge clk);
        pin_in = 32'h0000_0001;
        bus_addr = 5'd7;
        @(negedge clk);
        chk("R8 one edge", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R8 two edges", bus_rdata, 32'h8000_0000);

        // R9: unused words read zero
        rd(5'd25, r);
        chk("R9 unused", r, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule